// File: doc/BRIEF.md
# Per-Instruction Clock Select and Replay Controller

This controller sits beside the execute stage of a pipelined processor whose clock period is chosen per instruction. A classifier upstream predicts the delay class of each instruction about to enter execute. The controller registers that class as a clock-select code, so the execute stage runs that instruction at the matching period. The code changes only at a cycle boundary. Each class stands for a slice of the worst-case period. The slice upper bounds, in picoseconds, are parameters. The defaults are 1800, 2600 and 4000 ps, with 4000 ps as the worst case.

Timing errors are caught by comparing two samples of the execute result: the main capture and a later shadow capture. If they differ while a predicted instruction is in execute, the controller does four things in the same cycle:
- It raises a one-cycle flush, so the bad result and the younger instruction issued alongside it are discarded.
- It stalls the front end for a fixed replay window.
- It forces the worst-case select while the instruction re-executes.
- It bumps a saturating replay counter.

A replayed instruction runs at the worst-case period and cannot fault again. Predicted selection resumes when the window ends.

Top module: `clk_replay_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, clk_sel is the worst class code (2), sel_period_ps is 4000, stall and flush are 0, and replay_cnt is 0.
- R2: In normal mode, an issue with class code c (0, 1 or 2) sets clk_sel to c and sel_period_ps to 1800, 2600 or 4000 after the next rising edge.
- R3: A class code of 3 or above is clamped to the worst code 2 (period 4000).
- R4: A cycle with issue_valid low leaves clk_sel unchanged. Equal main and shadow samples cause no flush and no stall.
- R5: A mismatch between exe_main and exe_shadow, in the cycle after an accepted issue, gives flush=1 for exactly one cycle, stall=1 and clk_sel=2 after the next edge.
- R6: Stall stays high for exactly REPLAY_CYCLES (4) cycles from the flush cycle on, and clk_sel is 2 throughout.
- R7: While stall is high, issues and sample mismatches are ignored: there is no new flush, no counter step, and clk_sel stays at 2. This includes an issue in the last stall cycle.
- R8: A mismatch while no accepted instruction is in execute is ignored.
- R9: An issue presented in the same cycle as a detected violation is squashed and does not change clk_sel.
- R10: replay_cnt rises by one on each flush and saturates at 15 (CNT_W=4).
- R11: After the replay window ends, the next issue is again selected from its predicted class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction enters execute at the next edge |
| pred_class | input | SEL_W (2) | Predicted delay class of that instruction |
| exe_main | input | DATA_W (32) | Main capture of the execute result |
| exe_shadow | input | DATA_W (32) | Late shadow capture of the execute result |
| clk_sel | output | SEL_W (2) | Registered clock-select code for execute |
| sel_period_ps | output | PER_W (16) | Period bound of the selected class in ps |
| stall | output | 1 | Hold the stages ahead of execute |
| flush | output | 1 | Discard the faulting result and its younger neighbour |
| replay_cnt | output | CNT_W (4) | Saturating count of replays |

## Verification
The assertions assume that the front end honours stall: issue_valid and the two samples may take any value during a stall, because the controller must ignore them. They also assume that the two samples are only meaningful in the cycle after an accepted issue. The stimulus holds reset for several cycles before any check. It drives inputs only on falling edges and deliberately presents mismatches and issues during stall, idle cycles and the violation cycle itself. Every replay is therefore started by a mismatch aligned to a real execute cycle.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_REPLAY = 1'b1} ctl_state_t;
endpackage

// File: rtl/ccs_class_map.sv
module ccs_class_map #(
  parameter int NUM_CLASSES = 3,
  parameter int SEL_W       = 2,
  parameter int PER_W       = 16,
  parameter logic [NUM_CLASSES*PER_W-1:0] BOUND_PS = {16'd4000, 16'd2600, 16'd1800}
) (
  input  logic [SEL_W-1:0] pred_class,
  input  logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] cls_eff,
  output logic [PER_W-1:0] period_ps
);
  localparam logic [SEL_W-1:0] WORST = SEL_W'(NUM_CLASSES - 1);

  logic [PER_W-1:0] bound_tbl [NUM_CLASSES];

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_tbl
    assign bound_tbl[g] = BOUND_PS[g*PER_W +: PER_W];
  end

  // codes past the last class fall back to the slowest period
  always_comb begin
    if (pred_class > WORST) cls_eff = WORST;
    else                    cls_eff = pred_class;
  end

  always_comb begin
    if (sel_q > WORST) period_ps = bound_tbl[NUM_CLASSES-1];
    else               period_ps = bound_tbl[sel_q];
  end

  // R3: the clamped code always names an existing class
  always_comb begin
    if (!$isunknown(pred_class))
      a_r3_clamp_in_range: assert (cls_eff <= WORST);
  end
endmodule

// File: rtl/ccs_shadow_cmp.sv
module ccs_shadow_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] main_smp,
  input  logic [DATA_W-1:0] late_smp,
  output logic              mismatch
);
  logic [DATA_W-1:0] diff;
  assign diff     = main_smp ^ late_smp;
  assign mismatch = |diff;
endmodule

// File: rtl/ccs_replay_fsm.sv
module ccs_replay_fsm
  import ccs_pkg::*;
#(
  parameter int SEL_W         = 2,
  parameter int NUM_CLASSES   = 3,
  parameter int REPLAY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [SEL_W-1:0] cls_eff,
  input  logic             mismatch,
  output logic [SEL_W-1:0] clk_sel,
  output logic             stall,
  output logic             flush,
  output logic             viol
);
  localparam logic [SEL_W-1:0] WORST = SEL_W'(NUM_CLASSES - 1);
  localparam int RC_W = (REPLAY_CYCLES > 1) ? $clog2(REPLAY_CYCLES) : 1;
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(REPLAY_CYCLES - 1);

  ctl_state_t      state;
  logic [RC_W-1:0] win_cnt;
  logic            exe_busy;

  // a predicted instruction is in execute and its two captures disagree
  assign viol = (state == ST_RUN) && exe_busy && mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      win_cnt  <= '0;
      exe_busy <= 1'b0;
      clk_sel  <= WORST;
      stall    <= 1'b0;
      flush    <= 1'b0;
    end else begin
      flush <= 1'b0;
      case (state)
        ST_RUN: begin
          if (viol) begin
            state    <= ST_REPLAY;
            stall    <= 1'b1;
            flush    <= 1'b1;
            clk_sel  <= WORST;
            win_cnt  <= RC_LOAD;
            exe_busy <= 1'b0;
          end else begin
            exe_busy <= issue_valid;
            if (issue_valid) clk_sel <= cls_eff;
          end
        end
        ST_REPLAY: begin
          exe_busy <= 1'b0;
          if (win_cnt == '0) begin
            state <= ST_RUN;
            stall <= 1'b0;
          end else begin
            win_cnt <= win_cnt - 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // checker state: length of the current stall run
  logic [15:0] stall_run;
  always_ff @(posedge clk) begin
    if (rst)        stall_run <= '0;
    else if (flush) stall_run <= 16'd1;
    else if (stall) stall_run <= stall_run + 16'd1;
    else            stall_run <= '0;
  end

  a_r5_flush_single: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  a_r5_flush_with_stall: assert property (@(posedge clk) disable iff (rst)
    flush |-> stall);
  a_r6_worst_while_stalled: assert property (@(posedge clk) disable iff (rst)
    stall |-> (clk_sel == WORST));
  a_r6_window_length: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> (stall_run == 16'(REPLAY_CYCLES)));
  a_r7_quiet_replay: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> !flush);
endmodule

// File: rtl/ccs_sat_counter.sv
module ccs_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (inc && count != MAXV) count <= count + 1'b1;
  end

  a_r10_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (count == MAXV) |=> (count == MAXV));
  a_r10_step_only_on_inc: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/clk_replay_ctrl.sv
module clk_replay_ctrl #(
  parameter int NUM_CLASSES   = 3,
  parameter int PER_W         = 16,
  parameter logic [NUM_CLASSES*PER_W-1:0] BOUND_PS = {16'd4000, 16'd2600, 16'd1800},
  parameter int DATA_W        = 32,
  parameter int REPLAY_CYCLES = 4,
  parameter int CNT_W         = 4,
  localparam int SEL_W        = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [SEL_W-1:0]  pred_class,
  input  logic [DATA_W-1:0] exe_main,
  input  logic [DATA_W-1:0] exe_shadow,
  output logic [SEL_W-1:0]  clk_sel,
  output logic [PER_W-1:0]  sel_period_ps,
  output logic              stall,
  output logic              flush,
  output logic [CNT_W-1:0]  replay_cnt
);
  logic [SEL_W-1:0] cls_eff;
  logic             mismatch;
  logic             viol;

  ccs_class_map #(
    .NUM_CLASSES(NUM_CLASSES), .SEL_W(SEL_W), .PER_W(PER_W), .BOUND_PS(BOUND_PS)
  ) u_map (
    .pred_class(pred_class), .sel_q(clk_sel),
    .cls_eff(cls_eff), .period_ps(sel_period_ps)
  );

  ccs_shadow_cmp #(.DATA_W(DATA_W)) u_cmp (
    .main_smp(exe_main), .late_smp(exe_shadow), .mismatch(mismatch)
  );

  ccs_replay_fsm #(
    .SEL_W(SEL_W), .NUM_CLASSES(NUM_CLASSES), .REPLAY_CYCLES(REPLAY_CYCLES)
  ) u_fsm (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .cls_eff(cls_eff),
    .mismatch(mismatch), .clk_sel(clk_sel), .stall(stall), .flush(flush),
    .viol(viol)
  );

  ccs_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(viol), .count(replay_cnt)
  );
endmodule

// File: tb/sim_clk_replay_ctrl.sv
module sim_clk_replay_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [1:0]  pred_class = 2'd0;
  logic [31:0] exe_main = 32'd0;
  logic [31:0] exe_shadow = 32'd0;
  logic [1:0]  clk_sel;
  logic [15:0] sel_period_ps;
  logic        stall, flush;
  logic [3:0]  replay_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  clk_replay_ctrl u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .pred_class(pred_class),
    .exe_main(exe_main), .exe_shadow(exe_shadow), .clk_sel(clk_sel),
    .sel_period_ps(sel_period_ps), .stall(stall), .flush(flush),
    .replay_cnt(replay_cnt)
  );

  function automatic int per_of(input int s);
    if (s == 0) return 1800;
    if (s == 1) return 2600;
    return 4000;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, leave at the next falling edge
  task automatic cyc(input bit iss, input int cls, input bit mis, input int tag);
    issue_valid = iss;
    pred_class  = 2'(cls);
    exe_main    = 32'hA5A50000 + 32'(tag);
    exe_shadow  = exe_main ^ {31'd0, mis};
    @(negedge clk);
  endtask

  // fields: [15] iss [14:13] cls [12] mis [11:10] sel [9] stall [8] flush [7:4] cnt
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 class 0
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0}, // R4 idle hold, clean exe
    {1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 class 1
    {1'b1, 2'd3, 1'b0, 2'd2, 1'b0, 1'b0, 4'd0, 4'd0}, // R3 code 3 clamps
    {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 class 0 again
    {1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 4'd1, 4'd0}, // R5 R10 violation
    {1'b1, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 4'd1, 4'd0}, // R7 ignored in stall
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd1, 4'd0}, // R6
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd1, 4'd0}, // R6 fourth stall cycle
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 4'd1, 4'd0}, // R6 window over
    {1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 4'd1, 4'd0}, // R8 nothing in execute
    {1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 4'd1, 4'd0}, // R11 resume
    {1'b1, 2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 4'd2, 4'd0}, // R9 issue squashed
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd2, 4'd0}, // R6
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd2, 4'd0}, // R6
    {1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd2, 4'd0}, // R6
    {1'b1, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 4'd2, 4'd0}, // R7 issue in last stall cycle
    {1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 4'd2, 4'd0}, // R11 resume
    {1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd2, 4'd0}  // R4 clean exe, hold
  };

  initial begin : watchdog
    while (cycles < 100000) @(posedge clk) cycles++;
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1 state during reset
    chk("R1 sel", clk_sel, 2);
    chk("R1 period", sel_period_ps, 4000);
    chk("R1 stall", stall, 0);
    chk("R1 flush", flush, 0);
    chk("R1 cnt", replay_cnt, 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      cyc(v[15], int'(v[14:13]), v[12], i);
      chk($sformatf("vec%0d sel", i), clk_sel, int'(v[11:10]));
      chk($sformatf("vec%0d period R2", i), sel_period_ps, per_of(int'(v[11:10])));
      chk($sformatf("vec%0d stall", i), stall, int'(v[9]));
      chk($sformatf("vec%0d flush", i), flush, int'(v[8]));
      chk($sformatf("vec%0d cnt R10", i), replay_cnt, int'(v[7:4]));
    end

    // R10 saturation: count is 2, thirteen replays reach 15, one more holds
    for (int k = 0; k < 14; k++) begin
      cyc(1'b1, 0, 1'b0, 100);
      cyc(1'b0, 0, 1'b1, 101);
      chk("R5 flush on replay", flush, 1);
      for (int j = 0; j < 4; j++) cyc(1'b0, 0, 1'b0, 102);
      chk("R6 stall cleared", stall, 0);
    end
    chk("R10 saturated", replay_cnt, 15);

    // R1 reset in mid-run clears everything
    cyc(1'b1, 0, 1'b0, 200);
    chk("R2 before reset", clk_sel, 0);
    rst = 1'b1;
    cyc(1'b0, 0, 1'b0, 201);
    cyc(1'b0, 0, 1'b0, 202);
    rst = 1'b0;
    chk("R1 sel after reset", clk_sel, 2);
    chk("R1 cnt after reset", replay_cnt, 0);
    chk("R1 stall after reset", stall, 0);
    cyc(1'b0, 0, 1'b1, 203);
    chk("R8 no flush after reset", flush, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule